// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits between one processor core and a shared memory write port and gives the core an atomic read-modify-write primitive. A load-exclusive request records its effective address and access size and arms a local monitor. A later store-exclusive reaches memory only if all of the following hold: the monitor is still armed, the address and size match the recorded pair, and no other bus master has written the watched word in between. Every request gets a one-bit status, where 0 means the store was performed and 1 means it was refused.

The core presents a base address, an immediate offset, a size code and write data. Word accesses add the offset to the base. Byte and halfword accesses ignore the offset and use the base directly. A separate observation port reports writes made by other masters. Two further inputs disarm the monitor: an explicit clear, and the entry into an exception handler. The response and any memory write come out of registers, one clock after the request is taken.

Top module: `excl_monitor`

## Requirements
- R1: A performed store-exclusive returns status 0 and issues exactly one memory write, carrying its data, size and effective address. A refused store-exclusive returns status 1 and issues no memory write.
- R2: A store-exclusive is refused when its effective address differs from the address recorded by the most recent load-exclusive.
- R3: A store-exclusive is refused when its size code differs from the recorded size. The size codes are 0 for byte, 1 for halfword, 2 for word and 3 for invalid.
- R4: An observed write by another master is compared on address bits above bit 1. If it falls in the same aligned 4-byte word as the recorded address while the monitor is armed, it disarms the monitor. Such a write in the same cycle as a store-exclusive causes that store to be refused.
- R5: A word access uses base plus offset as its effective address. Byte and halfword accesses use the base alone, whatever the offset.
- R6: A request is flagged with rsp_err=1 and status 1, performs no write and leaves the monitor unchanged in any of these cases: size code 3, or a word offset that is not a multiple of 4 or is above 1020.
- R7: Every error-free store-exclusive disarms the monitor, whether it succeeds or not. A second store without a new load is therefore refused.
- R8: An error-free load-exclusive records its address and size, re-arms the monitor, replaces any earlier record, and returns status 0 with no memory write. It takes priority over a same-cycle observed write.
- R9: clr_mon or exc_entry disarms the monitor, with priority over a same-cycle load-exclusive. A store-exclusive in the same cycle is refused.
- R10: Each accepted request produces a single-cycle rsp_valid pulse in the cycle after acceptance. rsp_valid stays low in cycles that follow no request.
- R11: After reset the monitor is disarmed, and rsp_valid and mem_wr_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store-exclusive, 0 = load-exclusive |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 invalid |
| req_base | input | AW | Base address |
| req_offset | input | OFFW | Immediate offset (word only) |
| req_wdata | input | DW | Store data |
| snoop_valid | input | 1 | Another master writes this cycle |
| snoop_addr | input | AW | Address of that write |
| clr_mon | input | 1 | Explicit monitor clear |
| exc_entry | input | 1 | Exception entry, clears monitor |
| mem_wr_valid | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_size | output | 2 | Memory write size code |
| mem_wr_data | output | DW | Memory write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 1 | 0 = performed, 1 = refused or error |
| rsp_err | output | 1 | Offset or size error |

## Verification
The monitor's state is never visible at the ports. A wrong armed flag, tag address or tag size shows up only on the next store-exclusive, as a wrong status and a missing or extra memory write one cycle after that store. For this reason every scenario ends with a store-exclusive probe. The bench checks the status and the write port in the cycle right after each request, so a corrupted record is caught at the first store that depends on it.

// File: rtl/excl_pkg.sv
// Package: shared size encoding for the exclusive access monitor.
// Assumes a two-bit size code; code 3 is reserved and treated as an error.
package excl_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xsize_e;
endpackage

// File: rtl/excl_addr_gen.sv
// Effective-address former and request validator.
// Word accesses add the immediate offset; byte/halfword ignore it.
// Assumes AW >= OFFW so the offset fits the address width.
module excl_addr_gen
    import excl_pkg::*;
#(
    parameter int AW      = 16,
    parameter int OFFW    = 12,
    parameter int MAX_OFF = 1020
) (
    input  logic [1:0]      size,
    input  logic [AW-1:0]   base,
    input  logic [OFFW-1:0] offset,
    output logic [AW-1:0]   eff_addr,
    output logic            bad
);
    localparam int ALIGN_BITS = 2;

    logic off_misaligned;
    logic off_too_big;
    logic is_word;

    // Purpose: classify the offset and size code.
    always_comb begin
        is_word        = (xsize_e'(size) == SZ_WORD);
        off_misaligned = (offset[ALIGN_BITS-1:0] != '0);
        off_too_big    = (32'(offset) > MAX_OFF);
        bad            = (xsize_e'(size) == SZ_BAD) ||
                         (is_word && (off_misaligned || off_too_big));
    end

    // Purpose: form the effective address by size.
    always_comb begin
        if (is_word) eff_addr = base + AW'(offset);
        else         eff_addr = base;
    end
endmodule

// File: rtl/excl_tag_store.sv
// Monitor state: armed flag plus recorded address and size.
// Priority per cycle: kill > load arm > (store attempt | snoop hit) disarm.
// Snoop compare granule is 2**GRAN bytes.
module excl_tag_store #(
    parameter int AW   = 16,
    parameter int GRAN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kill,
    input  logic          load_arm,
    input  logic          store_try,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    output logic          pass
);
    logic          armed_q;
    logic [AW-1:0] tag_addr_q;
    logic [1:0]    tag_size_q;
    logic          snoop_hit;

    // Purpose: detect another master writing the watched granule.
    always_comb begin
        snoop_hit = snoop_valid && armed_q &&
                    (snoop_addr[AW-1:GRAN] == tag_addr_q[AW-1:GRAN]);
    end

    // Purpose: decide whether a store this cycle may write.
    always_comb begin
        pass = armed_q && !kill && !snoop_hit &&
               (addr == tag_addr_q) && (size == tag_size_q);
    end

    // Purpose: update the armed flag and recorded tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            tag_addr_q <= '0;
            tag_size_q <= '0;
        end else if (kill) begin
            armed_q <= 1'b0;
        end else if (load_arm) begin
            armed_q    <= 1'b1;
            tag_addr_q <= addr;
            tag_size_q <= size;
        end else if (store_try || snoop_hit) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/excl_resp_reg.sv
// Output register stage: response pulse and memory write, one cycle after
// the request edge. Data fields hold while strobes are low.
module excl_resp_reg #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rsp_v_d,
    input  logic          status_d,
    input  logic          err_d,
    input  logic          wr_v_d,
    input  logic [AW-1:0] wr_addr_d,
    input  logic [1:0]    wr_size_d,
    input  logic [DW-1:0] wr_data_d,
    output logic          rsp_valid,
    output logic          rsp_status,
    output logic          rsp_err,
    output logic          mem_wr_valid,
    output logic [AW-1:0] mem_wr_addr,
    output logic [1:0]    mem_wr_size,
    output logic [DW-1:0] mem_wr_data
);
    // Purpose: register strobes, status and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_status   <= 1'b0;
            rsp_err      <= 1'b0;
            mem_wr_valid <= 1'b0;
        end else begin
            rsp_valid    <= rsp_v_d;
            rsp_status   <= rsp_v_d && status_d;
            rsp_err      <= rsp_v_d && err_d;
            mem_wr_valid <= wr_v_d;
        end
    end

    // Purpose: capture write payload only when a write issues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr_addr <= '0;
            mem_wr_size <= '0;
            mem_wr_data <= '0;
        end else if (wr_v_d) begin
            mem_wr_addr <= wr_addr_d;
            mem_wr_size <= wr_size_d;
            mem_wr_data <= wr_data_d;
        end
    end
endmodule

// File: rtl/excl_monitor.sv
// Top: exclusive access monitor between one core and a memory write port.
// Requests are taken every cycle req_valid is high; the response follows
// one clock later. Assumes one outstanding exclusive reservation.
module excl_monitor #(
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int OFFW    = 12,
    parameter int MAX_OFF = 1020
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_store,
    input  logic [1:0]      req_size,
    input  logic [AW-1:0]   req_base,
    input  logic [OFFW-1:0] req_offset,
    input  logic [DW-1:0]   req_wdata,
    input  logic            snoop_valid,
    input  logic [AW-1:0]   snoop_addr,
    input  logic            clr_mon,
    input  logic            exc_entry,
    output logic            mem_wr_valid,
    output logic [AW-1:0]   mem_wr_addr,
    output logic [1:0]      mem_wr_size,
    output logic [DW-1:0]   mem_wr_data,
    output logic            rsp_valid,
    output logic            rsp_status,
    output logic            rsp_err
);
    localparam int GRAN = 2;

    logic [AW-1:0] eff_addr;
    logic          req_bad;
    logic          req_ok;
    logic          load_arm;
    logic          store_try;
    logic          kill;
    logic          pass;
    logic          write_go;
    logic          status_d;

    excl_addr_gen #(.AW(AW), .OFFW(OFFW), .MAX_OFF(MAX_OFF)) u_addr (
        .size     (req_size),
        .base     (req_base),
        .offset   (req_offset),
        .eff_addr (eff_addr),
        .bad      (req_bad)
    );

    // Purpose: split the request into arm, try and kill controls.
    always_comb begin
        req_ok    = req_valid && !req_bad;
        load_arm  = req_ok && !req_store;
        store_try = req_ok && req_store;
        kill      = clr_mon || exc_entry;
    end

    excl_tag_store #(.AW(AW), .GRAN(GRAN)) u_tag (
        .clk         (clk),
        .rst_n       (rst_n),
        .kill        (kill),
        .load_arm    (load_arm),
        .store_try   (store_try),
        .addr        (eff_addr),
        .size        (req_size),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .pass        (pass)
    );

    // Purpose: decide the write and the returned status.
    always_comb begin
        write_go = store_try && pass;
        status_d = req_bad || (req_store && !pass);
    end

    excl_resp_reg #(.AW(AW), .DW(DW)) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .rsp_v_d      (req_valid),
        .status_d     (status_d),
        .err_d        (req_bad),
        .wr_v_d       (write_go),
        .wr_addr_d    (eff_addr),
        .wr_size_d    (req_size),
        .wr_data_d    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_status   (rsp_status),
        .rsp_err      (rsp_err),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_size  (mem_wr_size),
        .mem_wr_data  (mem_wr_data)
    );
endmodule

// File: rtl/excl_monitor_chk.sv
// Checker for excl_monitor: port-level temporal properties, bound below.
module excl_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_store,
    input logic clr_mon,
    input logic exc_entry,
    input logic rsp_valid,
    input logic rsp_status,
    input logic rsp_err,
    input logic mem_wr_valid
);
    a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r1_write_only_on_success: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (rsp_valid && !rsp_status));

    a_r1_success_store_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store) |=> (!rsp_status == mem_wr_valid));

    a_r6_err_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_status && !mem_wr_valid));

    a_r9_kill_refuses_store: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && (clr_mon || exc_entry)) |=> rsp_status);
endmodule

bind excl_monitor excl_monitor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_store    (req_store),
    .clr_mon      (clr_mon),
    .exc_entry    (exc_entry),
    .rsp_valid    (rsp_valid),
    .rsp_status   (rsp_status),
    .rsp_err      (rsp_err),
    .mem_wr_valid (mem_wr_valid)
);

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = '0;
    logic [15:0] req_base = '0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        snoop_valid = 1'b0;
    logic [15:0] snoop_addr = '0;
    logic        clr_mon = 1'b0;
    logic        exc_entry = 1'b0;
    logic        mem_wr_valid;
    logic [15:0] mem_wr_addr;
    logic [1:0]  mem_wr_size;
    logic [31:0] mem_wr_data;
    logic        rsp_valid;
    logic        rsp_status;
    logic        rsp_err;

    int total = 0;
    int bad = 0;

    // Reference model state, built from the requirements.
    logic        m_armed = 1'b0;
    logic [15:0] m_addr = '0;
    logic [1:0]  m_size = '0;

    always #5 clk = ~clk;

    excl_monitor dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_base(req_base), .req_offset(req_offset),
        .req_wdata(req_wdata), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .clr_mon(clr_mon), .exc_entry(exc_entry), .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr(mem_wr_addr), .mem_wr_size(mem_wr_size),
        .mem_wr_data(mem_wr_data), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_err(rsp_err)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One request cycle with optional side inputs; checks the response.
    task automatic xreq(input logic st, input logic [1:0] sz, input logic [15:0] base,
                        input logic [11:0] off, input logic [31:0] d,
                        input logic snp, input logic [15:0] saddr,
                        input logic clr, input logic exc, input string tag);
        logic        e_err, e_pass, e_wr, e_st, hit;
        logic [15:0] eff;
        e_err = (sz == 2'd3) || (sz == 2'd2 && (off[1:0] != 2'b00 || off > 12'd1020));
        eff   = (sz == 2'd2) ? base + {4'd0, off} : base;
        hit   = snp && m_armed && (saddr[15:2] == m_addr[15:2]);
        e_pass = m_armed && !clr && !exc && !hit && eff == m_addr && sz == m_size;
        e_wr  = st && !e_err && e_pass;
        e_st  = e_err || (st && !e_pass);
        if (clr || exc)          m_armed = 1'b0;
        else if (!e_err && !st) begin m_armed = 1'b1; m_addr = eff; m_size = sz; end
        else if ((!e_err && st) || hit) m_armed = 1'b0;

        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_base = base;
        req_offset = off; req_wdata = d; snoop_valid = snp; snoop_addr = saddr;
        clr_mon = clr; exc_entry = exc;
        @(posedge clk);
        #1;
        chk(rsp_valid == 1'b1, tag, "rsp_valid", rsp_valid, 1);
        chk(rsp_status == e_st, tag, "status", rsp_status, e_st);
        chk(rsp_err == e_err, tag, "err", rsp_err, e_err);
        chk(mem_wr_valid == e_wr, tag, "wr_valid", mem_wr_valid, e_wr);
        if (e_wr) begin
            chk(mem_wr_addr == eff, tag, "wr_addr", mem_wr_addr, eff);
            chk(mem_wr_data == d, tag, "wr_data", mem_wr_data, d);
            chk(mem_wr_size == sz, tag, "wr_size", mem_wr_size, sz);
        end
        @(negedge clk);
        req_valid = 1'b0; snoop_valid = 1'b0; clr_mon = 1'b0; exc_entry = 1'b0;
    endtask

    // Idle cycle carrying only side inputs; response must stay low.
    task automatic idle(input logic snp, input logic [15:0] saddr,
                        input logic clr, input logic exc);
        if (clr || exc) m_armed = 1'b0;
        else if (snp && m_armed && saddr[15:2] == m_addr[15:2]) m_armed = 1'b0;
        @(negedge clk);
        snoop_valid = snp; snoop_addr = saddr; clr_mon = clr; exc_entry = exc;
        @(posedge clk);
        #1;
        chk(rsp_valid == 1'b0, "R10", "idle rsp_valid", rsp_valid, 0);
        chk(mem_wr_valid == 1'b0, "R10", "idle wr_valid", mem_wr_valid, 0);
        @(negedge clk);
        snoop_valid = 1'b0; clr_mon = 1'b0; exc_entry = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [11:0] offs [6];
        offs = '{12'd0, 12'd4, 12'd1020, 12'd1024, 12'd2, 12'd8};
        repeat (3) @(posedge clk);
        #1;
        chk(rsp_valid == 1'b0, "R11", "reset rsp_valid", rsp_valid, 0);
        chk(mem_wr_valid == 1'b0, "R11", "reset wr_valid", mem_wr_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: store right after reset finds the monitor disarmed.
        xreq(1, 2'd2, 16'h0100, 12'd0, 32'h11, 0, 0, 0, 0, "R11");

        // R1 R5 R6 R7: sweep size x offset; load, store, repeat store.
        for (int sz = 0; sz < 4; sz++) begin
            for (int oi = 0; oi < 6; oi++) begin
                logic [15:0] b;
                b = 16'h2000 + 16'(sz * 16'h0400) + 16'(oi * 16'h10);
                xreq(0, 2'(sz), b, offs[oi], 0, 0, 0, 0, 0, "R8");
                xreq(1, 2'(sz), b, offs[oi], 32'hA000 + 32'(sz*16+oi), 0, 0, 0, 0, "R1");
                xreq(1, 2'(sz), b, offs[oi], 32'h5, 0, 0, 0, 0, "R7");
            end
        end

        // R5: byte/half ignore the offset.
        xreq(0, 2'd0, 16'h3000, 12'd8, 0, 0, 0, 0, 0, "R5");
        xreq(1, 2'd0, 16'h3000, 12'd0, 32'h77, 0, 0, 0, 0, "R5");
        // R5: word base+offset equals another base with zero offset.
        xreq(0, 2'd2, 16'h3000, 12'd16, 0, 0, 0, 0, 0, "R5");
        xreq(1, 2'd2, 16'h3010, 12'd0, 32'h78, 0, 0, 0, 0, "R5");

        // R2: address mismatch sweep.
        for (int k = 0; k < 4; k++) begin
            xreq(0, 2'd1, 16'h4000, 0, 0, 0, 0, 0, 0, "R2");
            xreq(1, 2'd1, 16'h4000 + 16'(2 << k), 0, 32'h1, 0, 0, 0, 0, "R2");
        end
        // R3: size mismatch sweep over all pairs.
        for (int a = 0; a < 3; a++)
            for (int b2 = 0; b2 < 3; b2++) begin
                xreq(0, 2'(a), 16'h5000, 0, 0, 0, 0, 0, 0, "R3");
                xreq(1, 2'(b2), 16'h5000, 0, 32'h2, 0, 0, 0, 0, "R3");
            end

        // R4: snoop between, in granule and outside it.
        for (int s = 0; s < 8; s++) begin
            xreq(0, 2'd2, 16'h6004, 0, 0, 0, 0, 0, 0, "R4");
            idle(1, 16'h6000 + 16'(s * 2), 0, 0);
            xreq(1, 2'd2, 16'h6004, 0, 32'h3, 0, 0, 0, 0, "R4");
        end
        // R4: snoop in same cycle as store.
        xreq(0, 2'd2, 16'h6004, 0, 0, 0, 0, 0, 0, "R4");
        xreq(1, 2'd2, 16'h6004, 0, 32'h4, 1, 16'h6007, 0, 0, "R4");
        // R8: load wins over same-cycle snoop.
        xreq(0, 2'd2, 16'h6004, 0, 0, 1, 16'h6004, 0, 0, "R8");
        xreq(1, 2'd2, 16'h6004, 0, 32'h5, 0, 0, 0, 0, "R8");
        // R8: newer load replaces older record.
        xreq(0, 2'd2, 16'h7000, 0, 0, 0, 0, 0, 0, "R8");
        xreq(0, 2'd0, 16'h7100, 0, 0, 0, 0, 0, 0, "R8");
        xreq(1, 2'd2, 16'h7000, 0, 32'h6, 0, 0, 0, 0, "R8");
        xreq(0, 2'd2, 16'h7000, 0, 0, 0, 0, 0, 0, "R8");
        xreq(0, 2'd0, 16'h7100, 0, 0, 0, 0, 0, 0, "R8");
        xreq(1, 2'd0, 16'h7100, 0, 32'h7, 0, 0, 0, 0, "R8");
        // R6: error load leaves the armed record intact.
        xreq(0, 2'd2, 16'h7200, 0, 0, 0, 0, 0, 0, "R6");
        xreq(0, 2'd2, 16'h7300, 12'd3, 0, 0, 0, 0, 0, "R6");
        xreq(1, 2'd3, 16'h7200, 0, 32'h8, 0, 0, 0, 0, "R6");
        xreq(1, 2'd2, 16'h7200, 0, 32'h9, 0, 0, 0, 0, "R6");

        // R9: clear and exception, idle and same-cycle.
        for (int m = 0; m < 2; m++) begin
            xreq(0, 2'd2, 16'h8000, 0, 0, 0, 0, 0, 0, "R9");
            idle(0, 0, m == 0, m == 1);
            xreq(1, 2'd2, 16'h8000, 0, 32'hB, 0, 0, 0, 0, "R9");
            xreq(0, 2'd2, 16'h8000, 0, 0, 0, 0, 0, 0, "R9");
            xreq(1, 2'd2, 16'h8000, 0, 32'hC, 0, 0, m == 0, m == 1, "R9");
            xreq(0, 2'd2, 16'h8000, 0, 0, 0, 0, m == 0, m == 1, "R9");
            xreq(1, 2'd2, 16'h8000, 0, 32'hD, 0, 0, 0, 0, "R9");
        end
        idle(0, 0, 0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule